// File: doc/BRIEF.md
# Change-of-State Interrupt Detector

The block watches a vector of already-synchronized input lines, grouped into equal banks of eight, and raises a sticky flag for every line on which an armed transition is seen. A single enable byte arms, per bank, detection of low-to-high and high-to-low transitions independently. The flags form a status word that the host reads either one lane at a time or as a whole word. The host clears flags by writing ones to them, so it can write back exactly what it read without losing events that arrived in between.

One level interrupt output is high while any flag is set and low while the whole status word is zero. A zero status word tells the host that this block did not raise the interrupt. Transitions are found by comparing each sample with the one before it. After reset the first sample only primes that history, so lines that are already high at reset do not produce a false event.

Top module: `cos_detector`

## Requirements
- R1: Lane k (k = 0..3) of the status word holds the flags of lines 8k..8k+7, and bit j of the lane belongs to line 8k+j. With `rd_word_i` high, `rd_data_o` returns the whole word with lane k at bits 8k+7:8k. With `rd_word_i` low it returns lane `rd_lane_i` in bits 7:0, with bits 31:8 zero.
- R2: `enable_i` bit k (k = 0..3) arms low-to-high detection for bank k. Bank k is lines 8k..8k+7.
- R3: `enable_i` bit k+4 arms high-to-low detection for bank k.
- R4: An armed transition on a line sets that line's flag. The line value is sampled at clock edge t, differs from the value sampled at edge t-1, and the flag reads set after edge t. The flag then stays set until it is cleared.
- R5: A write (`wr_i` high) clears flag bit j of lane k only when `wr_be_i[k]` is 1 and `wr_data_i[8k+j]` is 1. Zero data bits and lanes without byte enable are left unchanged.
- R6: `irq_o` is high exactly when at least one status flag is set, and it is low whenever the status word is zero.
- R7: If an armed transition and a clear of the same flag occur at the same clock edge, the flag is set after that edge.
- R8: When both directions are armed for a bank, a rise and a later fall of one line each set the same flag.
- R9: Disarming a bank stops new flags in that bank but leaves flags that are already set unchanged.
- R10: Reset clears all flags. The first sample after reset only loads the transition history, so no flag is set on that edge whatever the line levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lines_i | input | 32 | Synchronized input lines, four banks of eight |
| enable_i | input | 8 | Rising arm bits 3:0, falling arm bits 7:4, one per bank |
| wr_i | input | 1 | Status write strobe (write one to clear) |
| wr_be_i | input | 4 | Byte lane enables for the write |
| wr_data_i | input | 32 | Write data; ones select flags to clear |
| rd_word_i | input | 1 | 1: read whole status word, 0: read one lane |
| rd_lane_i | input | 2 | Lane index for a byte read |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt, high while any flag is set |

## Verification
The assertions check on every cycle the rules that govern each flag. An armed transition sets its flag on the following edge, even when a clear for that flag arrives at the same edge. A flag that is set and not cleared stays set. No flag appears without an armed transition behind it, and nothing is flagged during the priming cycle. They also check that the interrupt is low whenever a whole-word read returns zero. The bench scenarios show the behaviours that depend on the ports as a whole: the lane ordering and the byte-read zero extension, the way the enable bits map to banks and directions, the per-lane byte-enabled clear, and the acknowledge in which the host writes back exactly what it read. It also shows that flags survive disarming and that no false event follows reset.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int unsigned LANE_W_DEF    = 8;
  localparam int unsigned NUM_LANES_DEF = 4;

  typedef enum logic [0:0] {
    RD_LANE = 1'b0,
    RD_WORD = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/cos_edge_bank.sv
module cos_edge_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         primed_i,
  input  logic [W-1:0] line_i,
  input  logic         arm_rise_i,
  input  logic         arm_fall_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] status_q;
  logic [W-1:0] rise, fall, hit;

  always_comb begin
    rise = line_i & ~prev_q;
    fall = ~line_i & prev_q;
    hit  = primed_i ? ((rise & {W{arm_rise_i}}) | (fall & {W{arm_fall_i}})) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= line_i;
      // set wins over clear
      status_q <= (status_q & ~clr_i) | hit;
    end
  end

  assign status_o = status_q;

  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit))); // R4
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hit & clr_i) != '0) |=> ((status_q & $past(hit & clr_i)) == $past(hit & clr_i))); // R7
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(status_q & ~clr_i)) == $past(status_q & ~clr_i))); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit)) == '0)); // R9
  AST_PRIME_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!primed_i && status_q == '0) |=> (status_q == '0)); // R10
endmodule

// File: rtl/cos_read_mux.sv
module cos_read_mux #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4,
  localparam int unsigned LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [W*N-1:0] status_i,
  input  logic           rd_word_i,
  input  logic [LW-1:0]  rd_lane_i,
  output logic [W*N-1:0] rd_data_o
);
  import cos_pkg::*;
  logic [W-1:0] lane_sel;

  always_comb begin
    lane_sel = '0;
    for (int k = 0; k < N; k++) begin
      if (rd_lane_i == LW'(k)) lane_sel = status_i[k*W +: W];
    end
  end

  always_comb begin
    if (rd_mode_e'(rd_word_i) == RD_WORD) rd_data_o = status_i;
    else                                  rd_data_o = {{(W*(N-1)){1'b0}}, lane_sel};
  end
endmodule

// File: rtl/cos_detector.sv
module cos_detector #(
  parameter int unsigned LANE_W    = cos_pkg::LANE_W_DEF,
  parameter int unsigned NUM_LANES = cos_pkg::NUM_LANES_DEF,
  localparam int unsigned TOT_W = LANE_W * NUM_LANES,
  localparam int unsigned LW    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [TOT_W-1:0]       lines_i,
  input  logic [2*NUM_LANES-1:0] enable_i,
  input  logic                   wr_i,
  input  logic [NUM_LANES-1:0]   wr_be_i,
  input  logic [TOT_W-1:0]       wr_data_i,
  input  logic                   rd_word_i,
  input  logic [LW-1:0]          rd_lane_i,
  output logic [TOT_W-1:0]       rd_data_o,
  output logic                   irq_o
);
  logic             primed_q;
  logic [TOT_W-1:0] status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_bank
    logic [LANE_W-1:0] clr;
    assign clr = (wr_i && wr_be_i[k]) ? wr_data_i[k*LANE_W +: LANE_W] : '0;

    cos_edge_bank #(.W(LANE_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .primed_i   (primed_q),
      .line_i     (lines_i[k*LANE_W +: LANE_W]),
      .arm_rise_i (enable_i[k]),
      .arm_fall_i (enable_i[k+NUM_LANES]),
      .clr_i      (clr),
      .status_o   (status[k*LANE_W +: LANE_W])
    );
  end

  cos_read_mux #(.W(LANE_W), .N(NUM_LANES)) u_rd (
    .status_i  (status),
    .rd_word_i (rd_word_i),
    .rd_lane_i (rd_lane_i),
    .rd_data_o (rd_data_o)
  );

  assign irq_o = |status;

  AST_IRQ_LOW_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_word_i && rd_data_o == '0) |-> !irq_o); // R6
  AST_IRQ_HIGH_ON_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_word_i && rd_data_o != '0) |-> irq_o); // R6
  AST_RESET_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |-> !irq_o); // R10
endmodule

// File: tb/cos_detector_tb.sv
module cos_detector_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lines_i = '0;
  logic [7:0]  enable_i = '0;
  logic        wr_i = 1'b0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_word_i = 1'b1;
  logic [1:0]  rd_lane_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [31:0] m_stat, m_prev;
  logic        m_primed;

  always #5 clk_i = ~clk_i;

  cos_detector u_dut (
    .clk_i, .rst_ni, .lines_i, .enable_i, .wr_i, .wr_be_i, .wr_data_i,
    .rd_word_i, .rd_lane_i, .rd_data_o, .irq_o
  );

  function automatic logic [31:0] f_hit(input logic [31:0] cur, input logic [31:0] prv,
                                        input logic [7:0] en, input logic primed);
    logic [31:0] h = '0;
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 8; j++) begin
        int b = 8*k + j;
        if (en[k]   &&  cur[b] && !prv[b]) h[b] = 1'b1;
        if (en[k+4] && !cur[b] &&  prv[b]) h[b] = 1'b1;
      end
    end
    return primed ? h : '0;
  endfunction

  function automatic logic [31:0] f_clr(input logic w, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] c = '0;
    for (int k = 0; k < 4; k++) if (w && be[k]) c[8*k +: 8] = d[8*k +: 8];
    return c;
  endfunction

  function automatic logic [31:0] f_rd(input logic [31:0] s, input logic word, input logic [1:0] ln);
    return word ? s : {24'h0, s[8*ln +: 8]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the next posedge
  task automatic step(input logic [31:0] ln, input logic [7:0] en, input logic w,
                      input logic [3:0] be, input logic [31:0] d);
    logic [31:0] h, c;
    @(negedge clk_i);
    lines_i = ln; enable_i = en; wr_i = w; wr_be_i = be; wr_data_i = d;
    h = f_hit(ln, m_prev, en, m_primed);
    c = f_clr(w, be, d);
    @(posedge clk_i);
    #1;
    m_stat = (m_stat & ~c) | h;
    m_prev = ln;
    m_primed = 1'b1;
    wr_i = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic word, input logic [1:0] ln);
    rd_word_i = word; rd_lane_i = ln;
    #1;
    check(tag, rd_data_o, f_rd(m_stat, word, ln));
    rd_word_i = 1'b1;
    #1;
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    logic [31:0] snap;
    seed = $urandom(32'h1d5e_0a77);
    m_stat = '0; m_prev = '0; m_primed = 1'b0;
    lines_i = 32'hA5C3_F00F;
    enable_i = 8'hFF;
    #22;
    check("R10 reset status", rd_data_o, 32'h0);
    check("R6 reset irq", {31'h0, irq_o}, 32'h0);
    rst_ni = 1'b1;
    // first sample only primes history
    step(32'hA5C3_F00F, 8'hFF, 1'b0, 4'h0, '0);
    check("R10 no false edge", rd_data_o, 32'h0);
    check("R6 irq low on zero", {31'h0, irq_o}, 32'h0);

    // R2: rise-only on bank 1
    step(32'h0, 8'h00, 1'b0, 4'h0, '0);
    step(32'h0, 8'h02, 1'b0, 4'h0, '0);
    step(32'hFFFF_FFFF, 8'h02, 1'b0, 4'h0, '0);
    check("R2 rise bank1 only", rd_data_o, 32'h0000_FF00);
    check("R6 irq high", {31'h0, irq_o}, 32'h1);
    // R1 lane reads
    rd_check("R1 lane1 read", 1'b0, 2'd1);
    rd_check("R1 lane0 read", 1'b0, 2'd0);
    // R5 write-back acknowledge
    step(32'hFFFF_FFFF, 8'h02, 1'b1, 4'h2, 32'h0000_FF00);
    check("R5 ack clears", rd_data_o, 32'h0);

    // R3: fall-only on bank 3
    step(32'h0, 8'h80, 1'b0, 4'h0, '0);
    check("R3 fall bank3 only", rd_data_o, 32'hFF00_0000);
    rd_check("R1 lane3 read", 1'b0, 2'd3);
    // R5: lane without byte enable untouched, zero bits untouched
    step(32'h0, 8'h80, 1'b1, 4'h7, 32'hFFFF_FFFF);
    check("R5 unselected lane kept", rd_data_o, 32'hFF00_0000);
    step(32'h0, 8'h80, 1'b1, 4'h8, 32'h0F00_0000);
    check("R5 partial clear", rd_data_o, 32'hF000_0000);

    // R8: both edges on bank 0 set the same bit
    step(32'h0, 8'h11, 1'b1, 4'hF, 32'hFFFF_FFFF);
    step(32'h0000_0001, 8'h11, 1'b0, 4'h0, '0);
    step(32'h0000_0001, 8'h11, 1'b1, 4'h1, 32'h1);
    check("R8 rise flagged then cleared", rd_data_o, 32'h0);
    step(32'h0, 8'h11, 1'b0, 4'h0, '0);
    check("R8 fall sets same bit", rd_data_o, 32'h0000_0001);

    // R7: edge and clear of same bit in same cycle
    step(32'h0000_0001, 8'h11, 1'b1, 4'h1, 32'h1);
    check("R7 set wins", rd_data_o, 32'h0000_0001);

    // R9: disarm keeps flags, blocks new
    step(32'h0000_0001, 8'h00, 1'b0, 4'h0, '0);
    step(32'h0000_0000, 8'h00, 1'b0, 4'h0, '0);
    step(32'h00FF_00FE, 8'h00, 1'b0, 4'h0, '0);
    check("R9 disarmed keeps flag", rd_data_o, 32'h0000_0001);

    // R4: random traffic, read-then-write-back acks
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] l, d;
      logic [7:0]  e;
      logic        w;
      logic [3:0]  b;
      l = $urandom;
      e = $urandom;
      w = ($urandom % 4) == 0;
      b = $urandom;
      d = (($urandom % 2) == 0) ? m_stat : $urandom;
      step(l, e, w, b, d);
      check("R4 random status", rd_data_o, m_stat);
      check("R6 random irq", {31'h0, irq_o}, {31'h0, (m_stat != 0)});
      if (i % 8 == 0) rd_check("R1 random lane", 1'b0, 2'($urandom));
    end
    snap = m_stat;
    step(m_prev, 8'h00, 1'b1, 4'hF, snap);
    check("R5 full write-back", rd_data_o, 32'h0);
    check("R6 irq after ack", {31'h0, irq_o}, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule